// File: doc/BRIEF.md
# Sequential Stream Prefetch Address Generator

This block turns one stream description into a run of cache-block prefetch addresses. A start command carries a 64-bit effective address, a direction bit, a 10-bit block count and an unbounded flag. The block then offers block-aligned addresses, one at a time, on a valid/ready request port. It moves one block up or one block down per accepted request. The stream ends when the count is used up or when the end of the address space is reached. An unbounded stream runs until a stop input arrives.

A region attribute input travels with the start command. It marks storage that is caching-inhibited or guarded, and such a stream issues nothing. A start command that arrives while a stream is running replaces that stream. Stop takes priority over a start in the same cycle. Block size is a power-of-two parameter.

Top module: `pfg_stream_gen`

## Requirements
- R1: The first request is valid in the cycle after the start command's clock edge. Its address is the start address with its low log2(BLK_BYTES) bits cleared.
- R2: For a forward stream (start_backward = 0), each accepted request is followed by a request one block size higher.
- R3: For a backward stream (start_backward = 1), each accepted request is followed by a request one block size lower.
- R4: A bounded stream (start_unbounded = 0) issues exactly start_count requests. req_valid is low in the cycle after the last handshake.
- R5: A bounded start with start_count = 0 issues no request.
- R6: With start_unbounded = 1, start_count is ignored and requests continue past it.
- R7: A stop pulse makes req_valid low from the next cycle on. If stop and start_valid are high in the same cycle, stop wins and no request follows.
- R8: A start with region_restricted = 1 (the attribute is sampled with the start command) issues no request.
- R9: While req_valid is high and req_ready is low, req_valid stays high and req_addr stays unchanged.
- R10: A forward stream ends after the topmost block of the 64-bit space, and a backward stream ends after block zero. Neither wraps around.
- R11: A start command during a running stream replaces it. The next request is the new aligned start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | One-cycle stream start command |
| start_addr | input | 64 | Effective start address |
| start_backward | input | 1 | 1 = step down by blocks, 0 = step up |
| start_count | input | 10 | Number of blocks in a bounded stream |
| start_unbounded | input | 1 | 1 = ignore count, run until stopped |
| region_restricted | input | 1 | Start region is caching-inhibited or guarded |
| stop | input | 1 | Ends the current stream |
| req_valid | output | 1 | Prefetch request present |
| req_ready | input | 1 | Consumer accepts the request |
| req_addr | output | 64 | Block-aligned prefetch address |

## Verification
Each result is due at a fixed distance from its stimulus. The first request appears one clock edge after the start command. The next address replaces the current one at the same edge that completes a handshake. A stop or a stream end clears req_valid at the edge that follows it. The bench drives inputs and samples outputs on the falling edge, half a period after each of these rising edges. Every check therefore reads the value due from the edge just before it. For the stall case, the address is compared on every falling edge while ready is held low. After each stop or stream end, the bench checks that req_valid is low for the following cycles.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    localparam int PFG_ADDR_W = 64;
    localparam int PFG_CNT_W  = 10;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pfg_state_e;

    typedef struct packed {
        logic                  backward;
        logic                  unbounded;
    } pfg_mode_t;

    function automatic logic bounded_empty(input logic unbounded,
                                           input logic [PFG_CNT_W-1:0] units);
        return !unbounded && (units == '0);
    endfunction

endpackage

// File: rtl/pfg_addr_step.sv
module pfg_addr_step #(
    parameter int IDX_W = 58
) (
    input  logic [IDX_W-1:0] blk_idx,
    input  logic             backward,
    output logic [IDX_W-1:0] next_idx,
    output logic             at_edge
);
    always_comb begin
        if (backward) begin
            next_idx = blk_idx - IDX_W'(1);
            at_edge  = (blk_idx == '0);
        end else begin
            next_idx = blk_idx + IDX_W'(1);
            at_edge  = &blk_idx;
        end
    end
endmodule

// File: rtl/pfg_unit_counter.sv
module pfg_unit_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign last = (cnt_q == CNT_W'(1));

    // R4: the counter is never decremented below zero
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (dec && !load) |-> (cnt_q != '0));
endmodule

// File: rtl/pfg_stream_gen.sv
module pfg_stream_gen
    import pfg_pkg::*;
#(
    parameter int ADDR_W    = PFG_ADDR_W,
    parameter int CNT_W     = PFG_CNT_W,
    parameter int BLK_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_valid,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              start_backward,
    input  logic [CNT_W-1:0]  start_count,
    input  logic              start_unbounded,
    input  logic              region_restricted,
    input  logic              stop,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr
);
    localparam int OFS_W = $clog2(BLK_BYTES);
    localparam int IDX_W = ADDR_W - OFS_W;

    pfg_state_e       state_q;
    pfg_mode_t        mode_q;
    logic [IDX_W-1:0] blk_q;
    logic [IDX_W-1:0] blk_next;
    logic             at_edge;
    logic             cnt_last;
    logic             launch;
    logic             fire;
    logic             finish;

    pfg_addr_step #(.IDX_W(IDX_W)) u_step (
        .blk_idx  (blk_q),
        .backward (mode_q.backward),
        .next_idx (blk_next),
        .at_edge  (at_edge)
    );

    assign launch = start_valid && !stop && !region_restricted
                    && !bounded_empty(start_unbounded, start_count);
    assign fire   = req_valid && req_ready;
    assign finish = fire && ((!mode_q.unbounded && cnt_last) || at_edge);

    pfg_unit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (launch),
        .load_val (start_count),
        .dec      (fire && !mode_q.unbounded),
        .last     (cnt_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= '0;
            blk_q   <= '0;
        end else if (stop) begin
            state_q <= ST_IDLE;
        end else if (start_valid) begin
            state_q <= launch ? ST_RUN : ST_IDLE;
            if (launch) begin
                mode_q.backward  <= start_backward;
                mode_q.unbounded <= start_unbounded;
                blk_q            <= start_addr[ADDR_W-1:OFS_W];
            end
        end else if (finish) begin
            state_q <= ST_IDLE;
        end else if (fire) begin
            blk_q <= blk_next;
        end
    end

    assign req_valid = (state_q == ST_RUN);
    assign req_addr  = {blk_q, {OFS_W{1'b0}}};

    // R1: every offered address is block aligned
    a_r1_aligned: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_addr[OFS_W-1:0] == '0));

    // R2: forward step after an accepted request
    a_r2_step_up: assert property (@(posedge clk) disable iff (rst)
        (fire && !start_valid && !stop && !mode_q.backward)
        |=> (!req_valid || req_addr == $past(req_addr) + ADDR_W'(BLK_BYTES)));

    // R3: backward step after an accepted request
    a_r3_step_down: assert property (@(posedge clk) disable iff (rst)
        (fire && !start_valid && !stop && mode_q.backward)
        |=> (!req_valid || req_addr == $past(req_addr) - ADDR_W'(BLK_BYTES)));

    // R5: empty bounded stream issues nothing
    a_r5_empty: assert property (@(posedge clk) disable iff (rst)
        (start_valid && !start_unbounded && start_count == '0) |=> !req_valid);

    // R7: stop clears the request port
    a_r7_stop: assert property (@(posedge clk) disable iff (rst)
        stop |=> !req_valid);

    // R8: restricted region issues nothing
    a_r8_restricted: assert property (@(posedge clk) disable iff (rst)
        (start_valid && region_restricted) |=> !req_valid);

    // R9: offered request is held while stalled
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready && !start_valid && !stop)
        |=> (req_valid && $stable(req_addr)));

    // R10: no wrap past the top of the address space
    a_r10_top: assert property (@(posedge clk) disable iff (rst)
        (fire && !mode_q.backward && (&req_addr[ADDR_W-1:OFS_W]) && !start_valid)
        |=> !req_valid);

    // R10: no wrap below address zero
    a_r10_bottom: assert property (@(posedge clk) disable iff (rst)
        (fire && mode_q.backward && (req_addr[ADDR_W-1:OFS_W] == '0) && !start_valid)
        |=> !req_valid);
endmodule

// File: tb/tb_pfg_stream_gen.sv
module tb_pfg_stream_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_valid = 1'b0;
    logic [63:0] start_addr = '0;
    logic        start_backward = 1'b0;
    logic [9:0]  start_count = '0;
    logic        start_unbounded = 1'b0;
    logic        region_restricted = 1'b0;
    logic        stop = 1'b0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [63:0] req_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    localparam logic [63:0] BLK = 64'd64;

    always #10 clk = ~clk;

    pfg_stream_gen dut (
        .clk(clk), .rst(rst), .start_valid(start_valid), .start_addr(start_addr),
        .start_backward(start_backward), .start_count(start_count),
        .start_unbounded(start_unbounded), .region_restricted(region_restricted),
        .stop(stop), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [63:0] a, input logic back, input logic [9:0] n,
                        input logic unb, input logic rs);
        start_addr = a; start_backward = back; start_count = n;
        start_unbounded = unb; region_restricted = rs; start_valid = 1'b1;
        @(negedge clk);
        start_valid = 1'b0; region_restricted = 1'b0;
    endtask

    task automatic take(input string req, input logic [63:0] exp);
        chk(req, {63'b0, req_valid}, 64'd1);
        chk(req, req_addr, exp);
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
    endtask

    task automatic idle_for(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            chk(req, {63'b0, req_valid}, 64'd0);
            @(negedge clk);
        end
    endtask

    task automatic do_stop();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    task automatic t_reset();
        idle_for("R1 reset", 1);
    endtask

    task automatic t_forward();
        send(64'h1234, 1'b0, 10'd3, 1'b0, 1'b0);
        take("R1 first aligned", 64'h1200);
        take("R2 forward step", 64'h1240);
        take("R2 forward step", 64'h1280);
        idle_for("R4 count exhausted", 3);
    endtask

    task automatic t_backward();
        send(64'h1000_0047, 1'b1, 10'd2, 1'b0, 1'b0);
        take("R3 first", 64'h1000_0040);
        take("R3 backward step", 64'h1000_0000);
        idle_for("R4 backward exhausted", 2);
    endtask

    task automatic t_zero();
        send(64'h4000, 1'b0, 10'd0, 1'b0, 1'b0);
        idle_for("R5 zero count", 4);
    endtask

    task automatic t_unbounded();
        send(64'h8000, 1'b0, 10'd1, 1'b1, 1'b0);
        for (int i = 0; i < 5; i++)
            take("R6 unbounded", 64'h8000 + BLK * i);
        chk("R6 still running", {63'b0, req_valid}, 64'd1);
        do_stop();
        idle_for("R7 stop", 3);
    endtask

    task automatic t_restricted();
        send(64'h5000, 1'b0, 10'd4, 1'b0, 1'b1);
        idle_for("R8 restricted", 4);
    endtask

    task automatic t_stall();
        send(64'h6010, 1'b0, 10'd2, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            chk("R9 hold valid", {63'b0, req_valid}, 64'd1);
            chk("R9 hold addr", req_addr, 64'h6000);
            @(negedge clk);
        end
        take("R9 after stall", 64'h6000);
        take("R9 next", 64'h6040);
        idle_for("R9 end", 1);
    endtask

    task automatic t_edges();
        send(64'hFFFF_FFFF_FFFF_FFA5, 1'b0, 10'd5, 1'b0, 1'b0);
        take("R10 top-1", 64'hFFFF_FFFF_FFFF_FF80);
        take("R10 top", 64'hFFFF_FFFF_FFFF_FFC0);
        idle_for("R10 no wrap up", 2);
        send(64'h50, 1'b1, 10'd5, 1'b0, 1'b0);
        take("R10 bottom+1", 64'h40);
        take("R10 bottom", 64'h0);
        idle_for("R10 no wrap down", 2);
    endtask

    task automatic t_restart();
        send(64'h2000, 1'b0, 10'd0, 1'b1, 1'b0);
        take("R11 old stream", 64'h2000);
        take("R11 old stream", 64'h2040);
        send(64'h9010, 1'b1, 10'd0, 1'b1, 1'b0);
        take("R11 new start", 64'h9000);
        take("R11 new step", 64'h8FC0);
        do_stop();
        idle_for("R11 stopped", 1);
    endtask

    task automatic t_stop_start();
        send(64'h3000, 1'b0, 10'd8, 1'b0, 1'b0);
        take("R7 running", 64'h3000);
        start_addr = 64'h7000; start_backward = 1'b0; start_count = 10'd4;
        start_unbounded = 1'b0; start_valid = 1'b1; stop = 1'b1;
        @(negedge clk);
        start_valid = 1'b0; stop = 1'b0;
        idle_for("R7 stop beats start", 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_forward();
        t_backward();
        t_zero();
        t_unbounded();
        t_restricted();
        t_stall();
        t_edges();
        t_restart();
        t_stop_start();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule